// File: doc/BRIEF.md
# Shared Timer Prescaler with Synchronized Start

This block sits between the I/O clock and two timer/counters. A single free-running divider produces single-cycle tap enables at one eighth, one sixty-fourth, one two-hundred-fifty-sixth and one thousand-and-twenty-fourth of the clock rate. Each timer has its own 3-bit clock select. The select picks one of four sources for that timer's count-enable pulse: nothing, every clock, one of the taps, or an edge of that timer's external pin. The external pin is resynchronized before its edge is detected.

An 8-bit control register holds two writable bits. The first is a divider-restart bit, which normally clears itself after one cycle. The second is a synchronization-mode bit; while it is set, the restart bit stays at whatever value was written. Software uses this to freeze both timers, load their counters, and then release both on the same clock edge by clearing the mode bit. The control logic is a four-state machine: `CS_RUN` (both bits 0), `CS_PULSE` (one-cycle restart), `CS_ARMED` (mode set, restart clear) and `CS_HOLD` (mode and restart set). Every register write moves the machine to the state named by the written pair of bits. With no write, `CS_PULSE` returns to `CS_RUN` and every other state stays where it is. Each timer's external pin has a two-state level tracker, `LVL_LO` and `LVL_HI`, whose transitions produce the rising and falling edge strobes.

Top module: `tmr_prescale_sync`

## Requirements
- R1: After reset, `ctl_rdata` reads 0x00, `hold` is 0, and with both selects at 000 neither count enable is asserted.
- R2: Select 000 never asserts that timer's count enable.
- R3: Select 001 asserts that timer's count enable on every cycle in which `hold` is 0.
- R4: Selects 010, 011, 100 and 101 give a one-cycle enable every 8, 64, 256 and 1024 cycles. Counting the first cycle with `hold` low as cycle 1, the first enable falls in cycle 8, 64, 256 or 1024.
- R5: Select 111 yields one enable per rising edge of the timer's pin, and select 110 yields one per falling edge. The enable is high only in the cycle that follows the second rising clock edge after the pin changes. Only the pin level counts, whoever drives it.
- R6: In the control register, bit 7 is synchronization mode and bit 0 is divider restart. Bits 6 to 1 always read 0. A write with `ctl_we` high takes effect at that clock edge.
- R7: Writing restart=1 with mode=0 makes bit 0 read 1 and `hold` high for exactly one cycle. Then bit 0 clears by itself and the divider restarts from zero.
- R8: While mode=1 and restart=1, both bits stay set without further writes, `hold` stays high, and no select produces any enable.
- R9: Writing mode=0 from the held state clears the restart bit and drops `hold`. Both timers then restart together: with equal non-pin selects, their enables are identical on every cycle.
- R10: Both timers use one divider, so a restart moves the tap phase for both of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read value |
| sel_a | input | 3 | Clock select of timer A |
| sel_b | input | 3 | Clock select of timer B |
| pin_a | input | 1 | External clock pin of timer A (asynchronous) |
| pin_b | input | 1 | External clock pin of timer B (asynchronous) |
| cnt_en_a | output | 1 | Count enable of timer A |
| cnt_en_b | output | 1 | Count enable of timer B |
| hold | output | 1 | High while the divider restart is asserted |

## Verification
The assertions take three things for granted about the inputs. A clock select is changed only while it is not on a pin source, so any two consecutive pin-edge enables come from the same select. The pin inputs move slowly enough that each edge comes out of the synchronizer as its own level change. Writes arrive only through `ctl_we`. The stimulus respects all three. It sets selects at falling clock edges between measurement windows, toggles pins at falling edges spaced several clocks apart, and issues each register write as a one-cycle strobe.

// File: rtl/tpre_pkg.sv
package tpre_pkg;

    localparam int REG_W     = 8;
    localparam int SYNC_BIT  = 7;
    localparam int RST_BIT   = 0;
    localparam int SEL_W     = 3;
    localparam int NUM_TAPS  = 4;
    localparam int NUM_TMR   = 2;

    // Clock-select encodings seen by each timer.
    typedef enum logic [SEL_W-1:0] {
        SRC_OFF    = 3'b000,
        SRC_DIRECT = 3'b001,
        SRC_DIV8   = 3'b010,
        SRC_DIV64  = 3'b011,
        SRC_DIV256 = 3'b100,
        SRC_DIV1K  = 3'b101,
        SRC_PIN_FL = 3'b110,
        SRC_PIN_RS = 3'b111
    } src_sel_e;

    // Control register state machine.
    typedef enum logic [1:0] {
        CS_RUN   = 2'd0,
        CS_PULSE = 2'd1,
        CS_ARMED = 2'd2,
        CS_HOLD  = 2'd3
    } ctl_state_e;

    // Synchronized pin level tracker.
    typedef enum logic {
        LVL_LO = 1'b0,
        LVL_HI = 1'b1
    } lvl_state_e;

    // log2 of each tap divisor, tap 0 is the fastest.
    function automatic int tap_shift(input int idx);
        case (idx)
            0:       return 3;
            1:       return 6;
            2:       return 8;
            default: return 10;
        endcase
    endfunction

    localparam int DIV_W = tap_shift(NUM_TAPS - 1);

endpackage

// File: rtl/tpre_ctl.sv
module tpre_ctl
    import tpre_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic             hold
);

    localparam logic [REG_W-1:0] SYNC_MASK = REG_W'(1) << SYNC_BIT;
    localparam logic [REG_W-1:0] RST_MASK  = REG_W'(1) << RST_BIT;

    ctl_state_e state_q, state_d;
    logic       w_sync, w_rst;

    assign w_sync = |(wdata & SYNC_MASK);
    assign w_rst  = |(wdata & RST_MASK);

    // Next-state decode.
    always_comb begin
        state_d = state_q;
        if (we) begin
            unique case ({w_sync, w_rst})
                2'b00: state_d = CS_RUN;
                2'b01: state_d = CS_PULSE;
                2'b10: state_d = CS_ARMED;
                2'b11: state_d = CS_HOLD;
                default: state_d = CS_RUN;
            endcase
        end else begin
            unique case (state_q)
                CS_RUN:   state_d = CS_RUN;
                CS_PULSE: state_d = CS_RUN;
                CS_ARMED: state_d = CS_ARMED;
                CS_HOLD:  state_d = CS_HOLD;
                default:  state_d = CS_RUN;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CS_RUN;
        else        state_q <= state_d;
    end

    // Outputs.
    always_comb begin
        rdata = '0;
        hold  = 1'b0;
        unique case (state_q)
            CS_RUN: begin
                hold = 1'b0;
            end
            CS_PULSE: begin
                rdata[RST_BIT] = 1'b1;
                hold           = 1'b1;
            end
            CS_ARMED: begin
                rdata[SYNC_BIT] = 1'b1;
            end
            CS_HOLD: begin
                rdata[SYNC_BIT] = 1'b1;
                rdata[RST_BIT]  = 1'b1;
                hold            = 1'b1;
            end
            default: begin
                hold = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/tpre_divider.sv
module tpre_divider
    import tpre_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hold,
    output logic [NUM_TAPS-1:0] taps
);

    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (hold) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
        localparam int SH = tap_shift(t);
        assign taps[t] = !hold && (cnt_q[SH-1:0] == {SH{1'b1}});
    end

endmodule

// File: rtl/tpre_edge.sv
module tpre_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    import tpre_pkg::*;

    logic [STAGES-1:0] sync_q;
    lvl_state_e        lvl_q, lvl_d;
    logic              lvl_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], pin};
    end

    assign lvl_now = sync_q[STAGES-1];

    always_comb begin
        unique case (lvl_q)
            LVL_LO:  lvl_d = lvl_now ? LVL_HI : LVL_LO;
            LVL_HI:  lvl_d = lvl_now ? LVL_HI : LVL_LO;
            default: lvl_d = LVL_LO;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= LVL_LO;
        else        lvl_q <= lvl_d;
    end

    always_comb begin
        rise = 1'b0;
        fall = 1'b0;
        unique case (lvl_q)
            LVL_LO:  rise = lvl_now;
            LVL_HI:  fall = !lvl_now;
            default: rise = 1'b0;
        endcase
    end

endmodule

// File: rtl/tpre_select.sv
module tpre_select
    import tpre_pkg::*;
(
    input  logic [SEL_W-1:0]    sel,
    input  logic                hold,
    input  logic [NUM_TAPS-1:0] taps,
    input  logic                rise,
    input  logic                fall,
    output logic                en
);

    src_sel_e src;
    logic     raw;

    assign src = src_sel_e'(sel);

    always_comb begin
        unique case (src)
            SRC_OFF:    raw = 1'b0;
            SRC_DIRECT: raw = 1'b1;
            SRC_DIV8:   raw = taps[0];
            SRC_DIV64:  raw = taps[1];
            SRC_DIV256: raw = taps[2];
            SRC_DIV1K:  raw = taps[3];
            SRC_PIN_FL: raw = fall;
            SRC_PIN_RS: raw = rise;
            default:    raw = 1'b0;
        endcase
    end

    assign en = raw && !hold;

endmodule

// File: rtl/tmr_prescale_sync.sv
module tmr_prescale_sync
    import tpre_pkg::*;
#(
    parameter int PIN_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [REG_W-1:0] ctl_wdata,
    output logic [REG_W-1:0] ctl_rdata,
    input  logic [SEL_W-1:0] sel_a,
    input  logic [SEL_W-1:0] sel_b,
    input  logic             pin_a,
    input  logic             pin_b,
    output logic             cnt_en_a,
    output logic             cnt_en_b,
    output logic             hold
);

    logic                hold_w;
    logic [NUM_TAPS-1:0] taps_w;
    logic [SEL_W-1:0]    sel_v  [NUM_TMR];
    logic                pin_v  [NUM_TMR];
    logic                en_v   [NUM_TMR];

    assign sel_v[0] = sel_a;
    assign sel_v[1] = sel_b;
    assign pin_v[0] = pin_a;
    assign pin_v[1] = pin_b;

    tpre_ctl u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl_we),
        .wdata (ctl_wdata),
        .rdata (ctl_rdata),
        .hold  (hold_w)
    );

    tpre_divider u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (hold_w),
        .taps  (taps_w)
    );

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        logic rise_w, fall_w;

        tpre_edge #(.STAGES(PIN_STAGES)) u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (pin_v[i]),
            .rise  (rise_w),
            .fall  (fall_w)
        );

        tpre_select u_sel (
            .sel   (sel_v[i]),
            .hold  (hold_w),
            .taps  (taps_w),
            .rise  (rise_w),
            .fall  (fall_w),
            .en    (en_v[i])
        );
    end

    assign cnt_en_a = en_v[0];
    assign cnt_en_b = en_v[1];
    assign hold     = hold_w;

endmodule

// File: rtl/tmr_prescale_sync_chk.sv
module tmr_prescale_sync_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_we,
    input logic [7:0] ctl_rdata,
    input logic [2:0] sel_a,
    input logic [2:0] sel_b,
    input logic       cnt_en_a,
    input logic       cnt_en_b,
    input logic       hold
);

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[6:1] == 6'd0) else $error("reserved bits set"); // R6

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a == 3'b000) |-> !cnt_en_a) else $error("off select enabled"); // R2

    AST_DIRECT_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_b == 3'b001 && !hold) |-> cnt_en_b) else $error("direct select missed"); // R3

    AST_PULSE_SELF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata[0] && !ctl_rdata[7] && !ctl_we) |=> !ctl_rdata[0]) else $error("restart stuck"); // R7

    AST_HOLD_RETAINED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata[7] && ctl_rdata[0] && !ctl_we) |=> (ctl_rdata[7] && ctl_rdata[0] && hold)) else $error("hold lost"); // R8

    AST_HOLD_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> !(cnt_en_a || cnt_en_b)) else $error("enable during hold"); // R8

    AST_PIN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en_a && sel_a[2:1] == 2'b11) |=> !(cnt_en_a && $stable(sel_a))) else $error("pin enable too long"); // R5

    AST_SAME_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a == sel_b && sel_a[2:1] != 2'b11) |-> (cnt_en_a == cnt_en_b)) else $error("timers out of step"); // R9

endmodule

bind tmr_prescale_sync tmr_prescale_sync_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .ctl_rdata (ctl_rdata),
    .sel_a     (sel_a),
    .sel_b     (sel_b),
    .cnt_en_a  (cnt_en_a),
    .cnt_en_b  (cnt_en_b),
    .hold      (hold)
);

// File: tb/tmr_prescale_sync_test.sv
module tmr_prescale_sync_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic [7:0] ctl_rdata;
    logic [2:0] sel_a = 3'b000;
    logic [2:0] sel_b = 3'b000;
    logic       pin_a = 1'b0;
    logic       pin_b = 1'b0;
    logic       cnt_en_a, cnt_en_b, hold;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    tmr_prescale_sync uut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .sel_a(sel_a), .sel_b(sel_b),
        .pin_a(pin_a), .pin_b(pin_b), .cnt_en_a(cnt_en_a),
        .cnt_en_b(cnt_en_b), .hold(hold)
    );

    // Source-table vectors: select, expected enables in the window, first cycle.
    localparam int NV  = 6;
    localparam int WIN = 2048;
    localparam int V_SEL   [NV] = '{0, 1, 2, 3, 4, 5};
    localparam int V_CNT   [NV] = '{0, 2048, 256, 32, 8, 2};
    localparam int V_FIRST [NV] = '{0, 1, 8, 64, 256, 1024};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] d);
        @(negedge clk);
        ctl_we = 1'b1;
        ctl_wdata = d;
        @(negedge clk);
        ctl_we = 1'b0;
        ctl_wdata = 8'h00;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int cnt_a, cnt_b, first_a, first_b, mism;

        // R1 reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ctl_rdata == 8'h00, "R1 rdata", ctl_rdata, 0);
        check(hold == 1'b0, "R1 hold", hold, 0);
        check(!cnt_en_a && !cnt_en_b, "R1 enables", {cnt_en_a, cnt_en_b}, 0);

        // Table walk: R2 R3 R4 R10
        for (int v = 0; v < NV; v++) begin
            sel_a = V_SEL[v][2:0];
            sel_b = V_SEL[NV-1-v][2:0];
            write_reg(8'h01);
            check(hold == 1'b1 && ctl_rdata == 8'h01, "R7 pulse visible", ctl_rdata, 1);
            cnt_a = 0; cnt_b = 0; first_a = 0; first_b = 0;
            for (int k = 1; k <= WIN; k++) begin
                @(negedge clk);
                if (k == 1) check(hold == 1'b0 && ctl_rdata == 8'h00, "R7 self clear", ctl_rdata, 0);
                if (cnt_en_a) begin cnt_a++; if (first_a == 0) first_a = k; end
                if (cnt_en_b) begin cnt_b++; if (first_b == 0) first_b = k; end
            end
            check(cnt_a == V_CNT[v], "R4 count timer A (R2 R3)", cnt_a, V_CNT[v]);
            check(first_a == V_FIRST[v], "R4 first timer A", first_a, V_FIRST[v]);
            check(cnt_b == V_CNT[NV-1-v], "R10 count timer B", cnt_b, V_CNT[NV-1-v]);
            check(first_b == V_FIRST[NV-1-v], "R10 first timer B", first_b, V_FIRST[NV-1-v]);
        end

        // R6 register layout
        write_reg(8'h7E);
        check(ctl_rdata == 8'h00, "R6 reserved bits", ctl_rdata, 0);
        write_reg(8'hFF);
        check(ctl_rdata == 8'h81, "R6 layout", ctl_rdata, 8'h81);

        // R8 held state: nothing advances
        sel_a = 3'b001; sel_b = 3'b010;
        cnt_a = 0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (k % 7 == 0) pin_a = ~pin_a;
            if (cnt_en_a || cnt_en_b || !hold) cnt_a++;
        end
        check(cnt_a == 0, "R8 frozen", cnt_a, 0);
        check(ctl_rdata == 8'h81, "R8 retained", ctl_rdata, 8'h81);
        sel_a = 3'b111;
        pin_a = ~pin_a;
        repeat (4) @(negedge clk);
        check(!cnt_en_a, "R8 pin gated", cnt_en_a, 0);
        pin_a = 1'b0;
        repeat (4) @(negedge clk);

        // R9 synchronized release
        sel_a = 3'b011; sel_b = 3'b011;
        write_reg(8'h00);
        check(ctl_rdata == 8'h00 && hold == 1'b0, "R9 restart cleared", ctl_rdata, 0);
        first_a = 0; first_b = 0; mism = 0;
        for (int k = 1; k <= 200; k++) begin
            if (k > 1) @(negedge clk);
            if (cnt_en_a != cnt_en_b) mism++;
            if (cnt_en_a && first_a == 0) first_a = k;
            if (cnt_en_b && first_b == 0) first_b = k;
        end
        check(mism == 0, "R9 lockstep", mism, 0);
        check(first_a == 64 && first_b == 64, "R9 first tap", first_a, 64);

        // R5 pin edges, rising then falling
        sel_a = 3'b111; sel_b = 3'b110;
        pin_a = 1'b0; pin_b = 1'b0;
        repeat (5) @(negedge clk);
        pin_a = 1'b1; pin_b = 1'b1;
        @(negedge clk);
        check(!cnt_en_a, "R5 rise latency early", cnt_en_a, 0);
        @(negedge clk);
        check(cnt_en_a && !cnt_en_b, "R5 rise pulse", cnt_en_a, 1);
        @(negedge clk);
        check(!cnt_en_a, "R5 rise single", cnt_en_a, 0);
        repeat (3) @(negedge clk);
        pin_a = 1'b0; pin_b = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(cnt_en_b && !cnt_en_a, "R5 fall pulse", cnt_en_b, 1);
        @(negedge clk);
        check(!cnt_en_b, "R5 fall single", cnt_en_b, 0);

        // R5 burst count
        cnt_a = 0; cnt_b = 0;
        for (int k = 0; k < 80; k++) begin
            @(negedge clk);
            if (k % 4 == 0) begin pin_a = ~pin_a; pin_b = ~pin_b; end
            if (cnt_en_a) cnt_a++;
            if (cnt_en_b) cnt_b++;
        end
        repeat (4) @(negedge clk);
        check(cnt_a == 10, "R5 rising count", cnt_a, 10);
        check(cnt_b == 10, "R5 falling count", cnt_b, 10);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule